// File: doc/BRIEF.md
# Sample-and-Hold Phase Sequencer

This block times a low-power sample-and-hold scheme for an external analog reference cell. A prescaler turns the module clock into a one-cycle tick every 2^ratio clocks. A frame counter advances on each tick. It repeats a frame of a programmed total length. Each frame opens with a sample phase and closes with a hold phase. Two strobes tell the analog cell which phase is active.

The sample length is not programmed on its own. It is the total count minus the hold count. Software must keep the hold count strictly below the total count. If it does not, the block stays in continuous sample and raises an error flag until a legal pair is applied. New counts are taken in only at a frame boundary, or while the sequencer is idle, so a running frame is never cut short.

Every pin is a plain level. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sh_phase_seq`

## Requirements
- R1: During and right after reset, sample_o, hold_o and cfg_err_o are all 0.
- R2: The sequencer runs only while mod_en_i and sh_mode_i are both 1. Otherwise sample_o, hold_o and cfg_err_o are all 0, even when the programmed counts are illegal.
- R3: With ratio_i = r, the frame position advances once every 2^r module clocks (divide by 1 up to 128). The first advance comes 2^r clocks after the run starts.
- R4: With legal counts T (total_i) and H (hold_i), clock k after run start (k = 0 in the first running cycle) is in frame position p = floor(k / 2^r) mod T. sample_o = 1 when p < T - H, and hold_o = 1 otherwise. Frames repeat with no gap.
- R5: H = 0 with T > 0 is legal. sample_o then stays 1 and hold_o never rises.
- R6: When the latched T is 0 or T <= H, cfg_err_o = 1, sample_o = 1 and hold_o = 0 while running. While in this state the counts are re-taken on every clock. A legal pair applied in cycle j makes the error clear in cycle j+1, and a new frame starts at position 0 in that cycle.
- R7: Clearing either enable forces hold_o and sample_o to 0 in the same cycle. It also returns the frame counter and the prescaler to zero, so the next run starts again at k = 0.
- R8: While running legally, new values of total_i and hold_i take effect only at the next frame boundary. The current frame keeps its length. While idle, the counts are taken on every clock.
- R9: sample_o and hold_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Module enable |
| sh_mode_i | input | 1 | Sample-and-hold mode enable |
| total_i | input | 16 | Total frame length in divided ticks |
| hold_i | input | 16 | Hold phase length in divided ticks |
| ratio_i | input | 3 | Divide exponent; tick every 2^ratio clocks |
| sample_o | output | 1 | Sample phase strobe |
| hold_o | output | 1 | Hold phase strobe |
| cfg_err_o | output | 1 | Illegal count pair latched while running |

## Verification
The main function is tried with random legal count pairs at small divide ratios, and with a directed run at the largest ratio. These show whether the tick spacing and the sample/hold split both follow the programmed values. Separate directed patterns each isolate one rule:
- A count change in mid-frame separates boundary-only loading from immediate loading.
- An equal pair, and then a legal pair, tells continuous-sample error handling apart from a correct recovery point.
- Dropping an enable during hold separates a clean restart from a resumed count.
- A zero hold count checks the edge of the legal range.

// File: rtl/sh_seq_pkg.sv
package sh_seq_pkg;
  parameter int unsigned CNT_W   = 16;
  parameter int unsigned RATIO_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/sh_prescaler.sv
module sh_prescaler #(
  parameter int unsigned RATIO_W = sh_seq_pkg::RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);
  localparam int unsigned DIV_W = (1 << RATIO_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  // terminal value is 2^ratio - 1; wraps to all ones for the top ratio
  assign limit  = (DIV_W'(1) << ratio_i) - DIV_W'(1);
  assign tick_o = run_i && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (!run_i)     div_q <= '0;
    else if (tick_o)     div_q <= '0;
    else                 div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/sh_cfg_latch.sv
module sh_cfg_latch #(
  parameter int unsigned CNT_W = sh_seq_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic [CNT_W-1:0] total_q,
  output logic [CNT_W-1:0] hold_q,
  output logic [CNT_W-1:0] samp_len_o,
  output logic             illegal_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      hold_q  <= '0;
    end else if (load_i) begin
      total_q <= total_i;
      hold_q  <= hold_i;
    end
  end

  assign illegal_o  = (total_q == '0) || (total_q <= hold_q);
  assign samp_len_o = total_q - hold_q;
endmodule

// File: rtl/sh_frame_ctr.sv
module sh_frame_ctr #(
  parameter int unsigned CNT_W = sh_seq_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             illegal_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] samp_len_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             frame_end_o,
  output logic             sample_o,
  output logic             hold_o
);
  logic [CNT_W-1:0] pos_q;
  logic             live;

  assign live        = run_i && !illegal_i;
  assign frame_end_o = live && tick_i && (pos_q == total_i - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pos_q <= '0;
    else if (!live)        pos_q <= '0;
    else if (frame_end_o)  pos_q <= '0;
    else if (tick_i)       pos_q <= pos_q + CNT_W'(1);
  end

  assign sample_o = run_i && (illegal_i || (pos_q < samp_len_i));
  assign hold_o   = live && (pos_q >= samp_len_i);
  assign pos_o    = pos_q;
endmodule

// File: rtl/sh_phase_seq.sv
module sh_phase_seq #(
  parameter int unsigned CNT_W   = sh_seq_pkg::CNT_W,
  parameter int unsigned RATIO_W = sh_seq_pkg::RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mod_en_i,
  input  logic               sh_mode_i,
  input  logic [CNT_W-1:0]   total_i,
  input  logic [CNT_W-1:0]   hold_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sample_o,
  output logic               hold_o,
  output logic               cfg_err_o
);
  logic             run;
  logic             tick;
  logic             illegal;
  logic             frame_end;
  logic             load;
  logic [CNT_W-1:0] tot_q;
  logic [CNT_W-1:0] hld_q;
  logic [CNT_W-1:0] samp_len;
  logic [CNT_W-1:0] pos_q;

  assign run  = mod_en_i && sh_mode_i;
  // counts are refreshed while idle, while illegal, and at frame end
  assign load = !run || illegal || frame_end;

  sh_prescaler #(.RATIO_W(RATIO_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .ratio_i (ratio_i),
    .tick_o  (tick)
  );

  sh_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .total_i    (total_i),
    .hold_i     (hold_i),
    .total_q    (tot_q),
    .hold_q     (hld_q),
    .samp_len_o (samp_len),
    .illegal_o  (illegal)
  );

  sh_frame_ctr #(.CNT_W(CNT_W)) u_frm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run),
    .tick_i      (tick),
    .illegal_i   (illegal),
    .total_i     (tot_q),
    .samp_len_i  (samp_len),
    .pos_o       (pos_q),
    .frame_end_o (frame_end),
    .sample_o    (sample_o),
    .hold_o      (hold_o)
  );

  assign cfg_err_o = run && illegal;
endmodule

// File: rtl/sh_phase_seq_chk.sv
module sh_phase_seq_chk #(
  parameter int unsigned CNT_W = sh_seq_pkg::CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_en_i,
  input logic             sh_mode_i,
  input logic             sample_o,
  input logic             hold_o,
  input logic             cfg_err_o,
  input logic [CNT_W-1:0] pos_q,
  input logic [CNT_W-1:0] tot_q,
  input logic [CNT_W-1:0] hld_q
);
  logic run_c;
  assign run_c = mod_en_i && sh_mode_i;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && hold_o));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_c |-> (!sample_o && !hold_o && !cfg_err_o));

  a_r6_err_sample: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (sample_o && !hold_o));

  a_r4_hold_to_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (run_c && $past(run_c) && $past(hold_o) && !hold_o) |-> sample_o);

  a_r8_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (run_c && $past(run_c) && pos_q != '0) |-> ($stable(tot_q) && $stable(hld_q)));

  a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run_c |=> (pos_q == '0));
endmodule

bind sh_phase_seq sh_phase_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_en_i  (mod_en_i),
  .sh_mode_i (sh_mode_i),
  .sample_o  (sample_o),
  .hold_o    (hold_o),
  .cfg_err_o (cfg_err_o),
  .pos_q     (pos_q),
  .tot_q     (tot_q),
  .hld_q     (hld_q)
);

// File: tb/sh_phase_seq_tb.sv
`timescale 1ns/1ps
module sh_phase_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic        sh_mode = 1'b0;
  logic [15:0] total = '0;
  logic [15:0] hold = '0;
  logic [2:0]  ratio = '0;
  logic        sample_o, hold_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sh_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en_i(mod_en), .sh_mode_i(sh_mode),
    .total_i(total), .hold_i(hold), .ratio_i(ratio),
    .sample_o(sample_o), .hold_o(hold_o), .cfg_err_o(cfg_err_o)
  );

  // expected {err, hold, sample} for cycle k of a run with fixed counts
  function automatic logic [2:0] exp_out(int k, int r, int t, int h);
    int p;
    if (t == 0 || t <= h) return 3'b101;
    p = (k >> r) % t;
    return (p < t - h) ? 3'b001 : 3'b010;
  endfunction

  task automatic chk(string req, logic [2:0] exp);
    n_chk++;
    if ({cfg_err_o, hold_o, sample_o} !== exp) begin
      n_bad++;
      $display("FAIL %s: got {err,hold,sample}=%b expected %b at %0t",
               req, {cfg_err_o, hold_o, sample_o}, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic setup(int r, int t, int h);
    cyc();
    mod_en = 1'b0; sh_mode = 1'b0;
    ratio = 3'(r); total = 16'(t); hold = 16'(h);
    cyc(); cyc();
  endtask

  // enable at the check of k = 0 and compare n cycles to the formula
  task automatic run_const(string req, int r, int t, int h, int n);
    setup(r, t, h);
    mod_en = 1'b1; sh_mode = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k != 0) cyc();
      #1 chk(req, exp_out(k, r, t, h));
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    cyc(); #1 chk("R1 in reset", 3'b000);
    cyc(); rst_n = 1'b1;
    cyc(); #1 chk("R1 after reset", 3'b000);

    // R2 only one enable set, illegal counts must stay silent
    setup(0, 0, 5);
    mod_en = 1'b1;
    for (int k = 0; k < 4; k++) begin cyc(); #1 chk("R2 mod only", 3'b000); end
    mod_en = 1'b0; sh_mode = 1'b1;
    for (int k = 0; k < 4; k++) begin cyc(); #1 chk("R2 mode only", 3'b000); end

    // R4 basic frame, R5 zero hold, R3 largest divide
    run_const("R4 T6 H2", 0, 6, 2, 20);
    run_const("R5 hold zero", 1, 5, 0, 24);
    run_const("R3 ratio 7", 7, 2, 1, 520);
    run_const("R3 ratio 2", 2, 4, 3, 40);

    // R4 random legal pairs
    for (int i = 0; i < 24; i++) begin
      int r, t, h;
      r = int'($urandom_range(0, 3));
      t = int'($urandom_range(1, 12));
      h = int'($urandom_range(0, t - 1));
      run_const("R4 random", r, t, h, 2 * t * (1 << r) + 4);
    end

    // R8 mid-frame change: old frame SSSSHH, then T3 H1 frames SSH
    setup(0, 6, 2);
    mod_en = 1'b1; sh_mode = 1'b1;
    for (int k = 0; k < 16; k++) begin
      if (k != 0) cyc();
      if (k == 2) begin total = 16'd3; hold = 16'd1; end
      #1 chk("R8 boundary load",
             (k < 6) ? exp_out(k, 0, 6, 2) : exp_out(k - 6, 0, 3, 1));
    end

    // R6 equal pair is an error, recovery one cycle after a legal pair
    run_const("R6 equal pair", 0, 5, 5, 4);
    for (int k = 4; k < 14; k++) begin
      cyc();
      if (k == 4) begin total = 16'd4; hold = 16'd1; end
      #1 chk("R6 recovery", (k == 4) ? 3'b101 : exp_out(k - 5, 0, 4, 1));
    end
    run_const("R6 total zero", 1, 0, 0, 6);

    // R7 drop enable during hold, restart fresh
    run_const("R7 pre", 0, 4, 2, 3);
    cyc(); mod_en = 1'b0;
    #1 chk("R7 drop same cycle", 3'b000);
    cyc(); #1 chk("R7 idle", 3'b000);
    cyc(); mod_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (k != 0) cyc();
      #1 chk("R7 restart", exp_out(k, 0, 4, 2));
    end
    cyc(); sh_mode = 1'b0;
    #1 chk("R7 mode drop", 3'b000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule